// File: doc/BRIEF.md
# Depth Pixel Qualification Stage

This stage sits at the end of a time-of-flight depth pipeline. For each pixel it takes the phase, amplitude and ambient values that the upstream arithmetic has already computed. It applies a per-frame-type phase offset that wraps around the phase range. It zeroes the phase of pixels that are too dim to trust or that are saturated by background light. It then builds a four-bit flag nibble that travels with the phase.

In normal mode the phase is 12 bits, where 4096 codes span one full turn. The nibble carries a saturation bit, a reserved zero and a two-bit frame counter. When two-frequency unwrapping is active upstream, the phase widens to 16 bits and the nibble carries the top four phase bits instead. The flags can then be routed into the ambient output field.

Pixels enter and leave on valid/ready streams through one register stage. The configuration is a set of plain input pins, sampled with each accepted pixel. A beat is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new pixel is taken.

Top module: `depth_qual_stage`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the frame counter is 0. A reset in the middle of a run returns the counter to 0.
- R2: When unwrapping is off, `out_phase` = (`in_phase[11:0]` + offset[11:0]) mod 4096. The offset is `cfg_ofs_base` when `in_supp`=0 and `cfg_ofs_supp` when `in_supp`=1. `in_phase[15:12]` has no effect.
- R3: With `cfg_corr_dis`=1 no offset is added, in either mode.
- R4: If `in_amp` < `cfg_amp_thr`, the whole output phase is zero: `out_phase`=0, and in unwrapping mode `out_flags`=0 as well. An amplitude equal to the threshold is not masked.
- R5: If `in_amb` <= `cfg_sat_thr`, the pixel is saturated and its whole output phase is zero. In normal mode flag bit 3 is 1. An ambient value of threshold+1 is not saturated.
- R6: In normal mode `out_flags` = {saturated, 1'b0, frame_count[1:0]}. That is, bit 3 is saturation, bit 2 is always 0 and bits 1:0 are the frame count.
- R7: The frame counter is two bits wide. It advances by one after each accepted pixel with `in_last`=1 and wraps from 3 to 0. `in_last` without an accepted beat has no effect. A pixel carries the count that held when it was accepted.
- R8: With `cfg_dealias`=1 the 16-bit phase is (`in_phase` + offset) mod 65536. `out_flags` carries bits 15:12 of that phase and `out_phase` carries bits 11:0.
- R9: With `cfg_dealias`=1 and `cfg_flags_to_amb`=1, `out_amb` = {8'h00, saturated, 1'b0, frame_count}. In every other case `out_amb` = `in_amb`.
- R10: One cycle of latency. A pixel accepted at an edge appears on the output after that edge. Order is kept, and a stalled output beat holds stable while `in_ready` stays low.
- R11: `out_last` equals the `in_last` of the same pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can accept a pixel |
| in_phase | input | 16 | Phase; bits 15:12 are used only in unwrapping mode |
| in_amp | input | 12 | Pixel amplitude |
| in_amb | input | 12 | Pixel ambient value |
| in_supp | input | 1 | 1 = supplementary frame, 0 = base frame |
| in_last | input | 1 | Last pixel of the frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_phase | output | 12 | Corrected, qualified phase bits 11:0 |
| out_flags | output | 4 | Flag nibble, or phase bits 15:12 in unwrapping mode |
| out_amb | output | 12 | Ambient value, or the flags when routed |
| out_last | output | 1 | Last pixel of the frame |
| cfg_corr_dis | input | 1 | Bypass the offset correction |
| cfg_dealias | input | 1 | Two-frequency unwrapping mode |
| cfg_flags_to_amb | input | 1 | Route the flags into `out_amb` (unwrapping mode only) |
| cfg_ofs_base | input | 16 | Phase offset for base frames |
| cfg_ofs_supp | input | 16 | Phase offset for supplementary frames |
| cfg_amp_thr | input | 12 | Minimum trusted amplitude |
| cfg_sat_thr | input | 12 | Ambient saturation threshold |

## Verification
The only state in this stage is the frame counter and the single output register. A counter that skips a step, misses a wrap, or counts beats that were never accepted shows up in flag bits 1:0 of the very next pixel. It also shows up in the ambient field when the flags are routed there, so the test drives five frame ends and checks every count. A wrong output-register enable shows at once, within a cycle of a stall. Either a held beat changes or is duplicated, or a second pixel is lost, so a stall is held for two cycles and then released in the same cycle that a new pixel is offered.

// File: rtl/dqs_pkg.sv
package dqs_pkg;
  // Positions inside the normal-mode flag nibble
  localparam int FLAG_SAT_BIT = 3;
  localparam int FLAG_RSV_BIT = 2;

  typedef enum logic {
    FRM_BASE = 1'b0,
    FRM_SUPP = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/dqs_phase_corr.sv
module dqs_phase_corr
  import dqs_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int EXT_W = 4,
  parameter int AMP_W = 12,
  localparam int FULL_W = PH_W + EXT_W
) (
  input  logic [FULL_W-1:0] phase_in,
  input  frame_kind_e       frame_kind,
  input  logic              dealias,
  input  logic              corr_dis,
  input  logic [FULL_W-1:0] ofs_base,
  input  logic [FULL_W-1:0] ofs_supp,
  input  logic [AMP_W-1:0]  amp,
  input  logic [AMP_W-1:0]  amb,
  input  logic [AMP_W-1:0]  amp_thr,
  input  logic [AMP_W-1:0]  sat_thr,
  output logic [FULL_W-1:0] phase_out,
  output logic              sat
);
  logic [FULL_W-1:0] ofs_sel, ofs_eff, wide_sum, corrected;
  logic [PH_W-1:0]   narrow_sum;
  logic              amp_low;

  always_comb begin
    ofs_sel    = (frame_kind == FRM_SUPP) ? ofs_supp : ofs_base;
    ofs_eff    = corr_dis ? '0 : ofs_sel;
    // Each sum wraps at its own width
    narrow_sum = phase_in[PH_W-1:0] + ofs_eff[PH_W-1:0];
    wide_sum   = phase_in + ofs_eff;
    corrected  = dealias ? wide_sum : {{EXT_W{1'b0}}, narrow_sum};
    amp_low    = (amp < amp_thr);
    sat        = (amb <= sat_thr);
    phase_out  = (amp_low || sat) ? '0 : corrected;
  end
endmodule

// File: rtl/dqs_flag_pack.sv
module dqs_flag_pack
  import dqs_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int EXT_W = 4,
  parameter int AMP_W = 12,
  parameter int FC_W  = 2,
  localparam int FULL_W = PH_W + EXT_W
) (
  input  logic [FULL_W-1:0] phase_full,
  input  logic              sat,
  input  logic [FC_W-1:0]   fcnt,
  input  logic              dealias,
  input  logic              route_to_amb,
  input  logic [AMP_W-1:0]  amb_in,
  output logic [PH_W-1:0]   phase_out,
  output logic [EXT_W-1:0]  flags_out,
  output logic [AMP_W-1:0]  amb_out
);
  logic [EXT_W-1:0] norm_flags;

  always_comb begin
    norm_flags               = '0;
    norm_flags[FC_W-1:0]     = fcnt;
    norm_flags[FLAG_RSV_BIT] = 1'b0;
    norm_flags[FLAG_SAT_BIT] = sat;
  end

  assign phase_out = phase_full[PH_W-1:0];
  assign flags_out = dealias ? phase_full[FULL_W-1:PH_W] : norm_flags;

  generate
    if (AMP_W > EXT_W) begin : g_wide_amb
      assign amb_out = (dealias && route_to_amb)
                       ? {{(AMP_W-EXT_W){1'b0}}, norm_flags} : amb_in;
    end else begin : g_narrow_amb
      assign amb_out = (dealias && route_to_amb) ? norm_flags[AMP_W-1:0] : amb_in;
    end
  endgenerate
endmodule

// File: rtl/dqs_frame_ctr.sv
module dqs_frame_ctr #(
  parameter int FC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [FC_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/depth_qual_stage.sv
module depth_qual_stage
  import dqs_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int EXT_W = 4,
  parameter int AMP_W = 12,
  parameter int FC_W  = 2,
  localparam int FULL_W = PH_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FULL_W-1:0] in_phase,
  input  logic [AMP_W-1:0]  in_amp,
  input  logic [AMP_W-1:0]  in_amb,
  input  logic              in_supp,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PH_W-1:0]   out_phase,
  output logic [EXT_W-1:0]  out_flags,
  output logic [AMP_W-1:0]  out_amb,
  output logic              out_last,
  input  logic              cfg_corr_dis,
  input  logic              cfg_dealias,
  input  logic              cfg_flags_to_amb,
  input  logic [FULL_W-1:0] cfg_ofs_base,
  input  logic [FULL_W-1:0] cfg_ofs_supp,
  input  logic [AMP_W-1:0]  cfg_amp_thr,
  input  logic [AMP_W-1:0]  cfg_sat_thr
);
  logic              take;
  logic [FC_W-1:0]   fcnt;
  logic [FULL_W-1:0] qual_phase;
  logic              qual_sat;
  logic [PH_W-1:0]   nxt_phase;
  logic [EXT_W-1:0]  nxt_flags;
  logic [AMP_W-1:0]  nxt_amb;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  dqs_frame_ctr #(.FC_W(FC_W)) u_fctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (take && in_last),
    .count (fcnt)
  );

  dqs_phase_corr #(.PH_W(PH_W), .EXT_W(EXT_W), .AMP_W(AMP_W)) u_corr (
    .phase_in   (in_phase),
    .frame_kind (frame_kind_e'(in_supp)),
    .dealias    (cfg_dealias),
    .corr_dis   (cfg_corr_dis),
    .ofs_base   (cfg_ofs_base),
    .ofs_supp   (cfg_ofs_supp),
    .amp        (in_amp),
    .amb        (in_amb),
    .amp_thr    (cfg_amp_thr),
    .sat_thr    (cfg_sat_thr),
    .phase_out  (qual_phase),
    .sat        (qual_sat)
  );

  dqs_flag_pack #(.PH_W(PH_W), .EXT_W(EXT_W), .AMP_W(AMP_W), .FC_W(FC_W)) u_pack (
    .phase_full   (qual_phase),
    .sat          (qual_sat),
    .fcnt         (fcnt),
    .dealias      (cfg_dealias),
    .route_to_amb (cfg_flags_to_amb),
    .amb_in       (in_amb),
    .phase_out    (nxt_phase),
    .flags_out    (nxt_flags),
    .amb_out      (nxt_amb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_phase <= '0;
      out_flags <= '0;
      out_amb   <= '0;
      out_last  <= 1'b0;
    end else if (take) begin
      out_phase <= nxt_phase;
      out_flags <= nxt_flags;
      out_amb   <= nxt_amb;
      out_last  <= in_last;
    end
  end
endmodule

// File: rtl/depth_qual_stage_chk.sv
module depth_qual_stage_chk
  import dqs_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int EXT_W = 4,
  parameter int AMP_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             cfg_dealias,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PH_W-1:0]  out_phase,
  input logic [EXT_W-1:0] out_flags,
  input logic [AMP_W-1:0] out_amb,
  input logic             out_last
);
  // Mode of the beat currently held in the output register
  logic beat_dealias;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    beat_dealias <= 1'b0;
    else if (in_valid && in_ready) beat_dealias <= cfg_dealias;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_phase) &&
    $stable(out_flags) && $stable(out_amb) && $stable(out_last));

  // R10
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10
  full_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6
  rsv_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !beat_dealias |-> !out_flags[FLAG_RSV_BIT]);

  // R5
  sat_zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !beat_dealias && out_flags[FLAG_SAT_BIT] |-> out_phase == '0);
endmodule

bind depth_qual_stage depth_qual_stage_chk #(
  .PH_W(PH_W), .EXT_W(EXT_W), .AMP_W(AMP_W)
) u_chk (.*);

// File: tb/depth_qual_stage_tb.sv
module depth_qual_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_phase = '0;
  logic [11:0] in_amp = '0, in_amb = '0;
  logic        in_supp = 1'b0, in_last = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [11:0] out_phase;
  logic [3:0]  out_flags;
  logic [11:0] out_amb;
  logic        out_last;
  logic        cfg_corr_dis = 1'b0, cfg_dealias = 1'b0, cfg_flags_to_amb = 1'b0;
  logic [15:0] cfg_ofs_base = 16'h2123, cfg_ofs_supp = 16'hF800;
  logic [11:0] cfg_amp_thr = 12'd100, cfg_sat_thr = 12'd50;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  depth_qual_stage u_dut (.*);

  typedef struct packed {
    logic        supp, dea, route, dis;
    logic [15:0] ph;
    logic [11:0] amp, amb;
    logic [11:0] eph;
    logic [3:0]  efl;
    logic [11:0] eamb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,16'h0100,12'd200,12'd300,12'h223,4'h0,12'd300},
    '{1'b0,1'b0,1'b0,1'b0,16'h5F00,12'd200,12'd300,12'h023,4'h0,12'd300},
    '{1'b1,1'b0,1'b0,1'b0,16'h0900,12'd200,12'd300,12'h100,4'h0,12'd300},
    '{1'b0,1'b0,1'b0,1'b1,16'h0ABC,12'd200,12'd300,12'hABC,4'h0,12'd300},
    '{1'b0,1'b0,1'b0,1'b0,16'h0100,12'd99, 12'd300,12'h000,4'h0,12'd300},
    '{1'b0,1'b0,1'b0,1'b0,16'h0100,12'd100,12'd300,12'h223,4'h0,12'd300},
    '{1'b0,1'b0,1'b0,1'b0,16'h0100,12'd200,12'd50, 12'h000,4'h8,12'd50},
    '{1'b0,1'b0,1'b0,1'b0,16'h0100,12'd200,12'd51, 12'h223,4'h0,12'd51},
    '{1'b0,1'b1,1'b0,1'b0,16'h3100,12'd200,12'd300,12'h223,4'h5,12'd300},
    '{1'b1,1'b1,1'b0,1'b0,16'h1000,12'd200,12'd300,12'h800,4'h0,12'd300},
    '{1'b0,1'b1,1'b1,1'b0,16'h3100,12'd200,12'd50, 12'h000,4'h0,12'h008},
    '{1'b0,1'b1,1'b1,1'b0,16'h3100,12'd200,12'd300,12'h223,4'h5,12'h000},
    '{1'b0,1'b0,1'b1,1'b0,16'h0100,12'd200,12'd300,12'h223,4'h0,12'd300},
    '{1'b0,1'b1,1'b0,1'b1,16'hABCD,12'd200,12'd300,12'hBCD,4'hA,12'd300},
    '{1'b0,1'b1,1'b0,1'b0,16'h3100,12'd99, 12'd300,12'h000,4'h0,12'd300}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2:  return "R2";
      3, 13:    return "R3";
      4, 5, 14: return "R4";
      6, 7:     return "R5";
      8, 9:     return "R8";
      default:  return "R9";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One pixel: drive at negedge, accept at posedge, sample at next negedge
  task automatic send(logic [15:0] ph, logic [11:0] amp, logic [11:0] amb, logic last);
    @(negedge clk);
    in_phase = ph; in_amp = amp; in_amb = amb; in_last = last; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "in_ready after reset", in_ready, 1);

    // Table walk, no frame ends so the count stays 0
    for (int i = 0; i < NV; i++) begin
      in_supp = VECS[i].supp; cfg_dealias = VECS[i].dea;
      cfg_flags_to_amb = VECS[i].route; cfg_corr_dis = VECS[i].dis;
      send(VECS[i].ph, VECS[i].amp, VECS[i].amb, 1'b0);
      chk("R10", "out_valid one cycle later", out_valid, 1);
      chk(tag_of(i), $sformatf("vec %0d phase", i), out_phase, VECS[i].eph);
      chk(tag_of(i), $sformatf("vec %0d flags", i), out_flags, VECS[i].efl);
      chk(tag_of(i), $sformatf("vec %0d amb", i), out_amb, VECS[i].eamb);
    end

    // R7 / R6 / R11: frame counter across five frame ends
    in_supp = 1'b0; cfg_dealias = 1'b0; cfg_flags_to_amb = 1'b0; cfg_corr_dis = 1'b1;
    for (int f = 0; f < 5; f++) begin
      send(16'h0040, 12'd200, 12'd300, 1'b1);
      chk("R7", $sformatf("frame %0d count", f), out_flags[1:0], f % 4);
      chk("R6", $sformatf("frame %0d flag nibble", f), out_flags, f % 4);
      chk("R11", "out_last", out_last, 1);
    end
    // count is now 1; last without valid must not advance it (R7)
    @(negedge clk); in_last = 1'b1;
    @(negedge clk); in_last = 1'b0;
    send(16'h0040, 12'd200, 12'd300, 1'b0);
    chk("R7", "last without handshake ignored", out_flags[1:0], 1);
    chk("R11", "out_last low", out_last, 0);

    // R9: routed flags carry the count
    cfg_dealias = 1'b1; cfg_flags_to_amb = 1'b1;
    send(16'h0040, 12'd200, 12'd300, 1'b0);
    chk("R9", "routed count in amb", out_amb, 12'h001);
    cfg_dealias = 1'b0; cfg_flags_to_amb = 1'b0;

    // R1: mid-run reset clears the counter
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "out_valid in mid-run reset", out_valid, 0);
    rst_n = 1'b1;
    send(16'h0040, 12'd200, 12'd300, 1'b0);
    chk("R1", "count after mid-run reset", out_flags[1:0], 0);

    // R10: back-pressure, hold and order
    @(negedge clk);
    out_ready = 1'b0;
    in_phase = 16'h0001; in_amp = 12'd200; in_amb = 12'd300; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10", "A valid", out_valid, 1);
    chk("R10", "in_ready low when stalled", in_ready, 0);
    chk("R10", "A phase", out_phase, 12'h001);
    in_phase = 16'h0002;
    @(posedge clk); @(negedge clk);
    chk("R10", "A held under stall", out_phase, 12'h001);
    chk("R10", "in_ready still low", in_ready, 0);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "B follows A", out_phase, 12'h002);
    chk("R10", "B valid", out_valid, 1);
    @(posedge clk); @(negedge clk);
    chk("R10", "drained", out_valid, 0);

    finish_run();
  end
endmodule